// File: doc/BRIEF.md
# CCD Drain Sequencer

This block produces the logic-level enables for the two vertical clock phases and the two drain gates of a full-frame CCD. It runs two operations. The first empties the whole array before an exposure. The second discards one or more lines during a partial readout. Draining always has the same shape. Charge is first gathered under the second vertical phase while the first phase stays low. The drain gate is pulsed only while that phase is high. The phase is then released. A gate-specific settling time must pass before the sequence counts as complete.

A controller gives a one-cycle start strobe. For a line discard it also gives a line count from 1 to 15. Every duration is a whole number of system-clock ticks, fixed by parameters. The vertical pulse width sets how long the first phase is high during a line shift, and also how long the second phase is high while it parks charge. A lead time keeps the drain gate clear of both edges of that window. The settling time for the array flush is longer than the settling time for the line discard. The block reports busy while a sequence runs and gives a one-cycle done pulse when it has finished.

Top module: `ccd_drain_seq`

## Requirements
- R1: Out of reset, and whenever no operation is running, `v1_en`, `v2_en`, `pfg_en`, `fdg_en`, `busy` and `done` are all low.
- R2: A flush starts in the cycle after `flush_go` is sampled. `v2_en` is high for `VW_TICKS` cycles while `v1_en` stays low. `pfg_en` is high for the middle `VW_TICKS-2*LEAD_TICKS` of those cycles, with `LEAD_TICKS` cycles of `v2_en` alone before it and after it.
- R3: After `v2_en` falls in a flush, all four enables stay low for `PFG_HOLD_TICKS` cycles before the done cycle.
- R4: Each discarded line begins with `VW_TICKS` cycles of `v1_en` high and `v2_en` low. A `v2_en` window follows, shaped as in R2, with `fdg_en` in place of `pfg_en`.
- R5: After each discarded line's `v2_en` falls, all enables stay low for `FDG_HOLD_TICKS` cycles.
- R6: A discard repeats the R4/R5 pattern exactly `dump_lines` times, back to back. A `dump_go` with `dump_lines` equal to 0 is ignored, and the outputs stay idle.
- R7: `done` is high for exactly one cycle, right after the last settling cycle, and `busy` is low in that cycle. `busy` is high from the first sequence cycle through the last settling cycle.
- R8: Start strobes that arrive while `busy` is high are ignored. The sequence already running is not changed.
- R9: If `flush_go` and `dump_go` are sampled together, the flush is performed.
- R10: A start strobe sampled in the done cycle is accepted. Its sequence begins in the next cycle.
- R11: `pfg_en` and `fdg_en` are never high while `v2_en` is low. `v1_en` and `v2_en` are never high together, and neither are `pfg_en` and `fdg_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_go | input | 1 | One-cycle request for a whole-array flush |
| dump_go | input | 1 | One-cycle request for a line discard |
| dump_lines | input | LINE_W (4) | Number of lines to discard, 1 to 15 |
| v1_en | output | 1 | Vertical phase 1 enable |
| v2_en | output | 1 | Vertical phase 2 enable |
| pfg_en | output | 1 | Whole-array drain gate enable |
| fdg_en | output | 1 | Single-row drain gate enable |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first sequence cycle is the cycle after the edge that samples a strobe. From there, every output of a flush or a discard has a fixed cycle given by the tick parameters: the line shift, the lead, the gate pulse, the trail, the settling time, and then the single done cycle. The driver computes this whole per-cycle output vector sequence when it issues a start. The monitor pops one entry per clock, a quarter period after the rising edge, and compares it with the six outputs. When the queue is empty, the monitor expects all outputs low. An ignored strobe pushes nothing, so any reaction to it shows up as a mismatch. A start placed in the done cycle falls out of the same rule, because the driver issues it as soon as the queue drains.

// File: rtl/ccd_drain_pkg.sv
package ccd_drain_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_XFER,   // line shift: phase 1 high
        PH_PARK,   // phase 2 high, gate not yet open
        PH_GATE,   // phase 2 high, drain gate open
        PH_TAIL,   // phase 2 high, gate closed again
        PH_HOLD,   // all low, settling
        PH_FIN     // one-cycle completion
    } phase_e;

    typedef enum logic {
        OP_FLUSH,
        OP_DUMP
    } op_e;

endpackage

// File: rtl/ccd_tick_timer.sv
module ccd_tick_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ccd_gate_decode.sv
module ccd_gate_decode
    import ccd_drain_pkg::*;
(
    input  phase_e ph,
    input  op_e    op,
    output logic   v1_en,
    output logic   v2_en,
    output logic   pfg_en,
    output logic   fdg_en,
    output logic   busy,
    output logic   done
);
    always_comb begin
        v1_en  = (ph == PH_XFER);
        v2_en  = (ph == PH_PARK) || (ph == PH_GATE) || (ph == PH_TAIL);
        pfg_en = (ph == PH_GATE) && (op == OP_FLUSH);
        fdg_en = (ph == PH_GATE) && (op == OP_DUMP);
        busy   = (ph != PH_IDLE) && (ph != PH_FIN);
        done   = (ph == PH_FIN);
    end
endmodule

// File: rtl/ccd_drain_seq.sv
module ccd_drain_seq
    import ccd_drain_pkg::*;
#(
    parameter int unsigned VW_TICKS       = 8,
    parameter int unsigned LEAD_TICKS     = 2,
    parameter int unsigned PFG_HOLD_TICKS = 24,
    parameter int unsigned FDG_HOLD_TICKS = 6,
    parameter int unsigned LINE_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_go,
    input  logic              dump_go,
    input  logic [LINE_W-1:0] dump_lines,
    output logic              v1_en,
    output logic              v2_en,
    output logic              pfg_en,
    output logic              fdg_en,
    output logic              busy,
    output logic              done
);
    localparam int unsigned GATE_TICKS = VW_TICKS - 2 * LEAD_TICKS;
    localparam int unsigned MAX_A = (VW_TICKS > PFG_HOLD_TICKS) ? VW_TICKS : PFG_HOLD_TICKS;
    localparam int unsigned MAX_T = (MAX_A > FDG_HOLD_TICKS) ? MAX_A : FDG_HOLD_TICKS;
    localparam int unsigned CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);

    typedef struct packed {
        phase_e            ph;
        op_e               op;
        logic [LINE_W-1:0] left;
    } seq_t;

    seq_t             s_d, s_q;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;

    function automatic logic [CNT_W-1:0] phase_len_m1(phase_e ph, op_e op);
        int unsigned n;
        case (ph)
            PH_XFER:          n = VW_TICKS;
            PH_PARK, PH_TAIL: n = LEAD_TICKS;
            PH_GATE:          n = GATE_TICKS;
            PH_HOLD:          n = (op == OP_FLUSH) ? PFG_HOLD_TICKS : FDG_HOLD_TICKS;
            default:          n = 1;
        endcase
        return CNT_W'(n - 1);
    endfunction

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE, PH_FIN: begin
                s_d.ph = PH_IDLE;
                if (flush_go) begin
                    s_d.op = OP_FLUSH;
                    s_d.ph = PH_PARK;
                end else if (dump_go && (dump_lines != '0)) begin
                    s_d.op   = OP_DUMP;
                    s_d.left = dump_lines;
                    s_d.ph   = PH_XFER;
                end
            end
            PH_XFER: if (expired) s_d.ph = PH_PARK;
            PH_PARK: if (expired) s_d.ph = PH_GATE;
            PH_GATE: if (expired) s_d.ph = PH_TAIL;
            PH_TAIL: if (expired) s_d.ph = PH_HOLD;
            PH_HOLD: begin
                if (expired) begin
                    if ((s_q.op == OP_DUMP) && (s_q.left > 1)) begin
                        s_d.left = s_q.left - 1'b1;
                        s_d.ph   = PH_XFER;
                    end else begin
                        s_d.ph = PH_FIN;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        load     = (s_d.ph != s_q.ph);
        load_val = phase_len_m1(s_d.ph, s_d.op);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph   <= PH_IDLE;
            s_q.op   <= OP_FLUSH;
            s_q.left <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    ccd_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    ccd_gate_decode u_decode (
        .ph     (s_q.ph),
        .op     (s_q.op),
        .v1_en  (v1_en),
        .v2_en  (v2_en),
        .pfg_en (pfg_en),
        .fdg_en (fdg_en),
        .busy   (busy),
        .done   (done)
    );
endmodule

// File: rtl/ccd_drain_seq_chk.sv
module ccd_drain_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic v1_en,
    input logic v2_en,
    input logic pfg_en,
    input logic fdg_en,
    input logic busy,
    input logic done
);
    // R11
    gate_needs_v2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pfg_en || fdg_en) |-> v2_en);

    // R11
    phase_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(v1_en && v2_en));

    // R11
    single_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pfg_en && fdg_en));

    // R2
    gate_closed_at_v2_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v2_en) |-> ($past(!pfg_en) && $past(!fdg_en)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    done_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy) && $past(!v2_en) && $past(!v1_en));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> !(v1_en || v2_en || pfg_en || fdg_en));
endmodule

bind ccd_drain_seq ccd_drain_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .v1_en  (v1_en),
    .v2_en  (v2_en),
    .pfg_en (pfg_en),
    .fdg_en (fdg_en),
    .busy   (busy),
    .done   (done)
);

// File: tb/ccd_drain_seq_tb.sv
module ccd_drain_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VW  = 8;
    localparam int LD  = 2;
    localparam int PH  = 24;
    localparam int FH  = 6;
    localparam int LW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_go = 1'b0;
    logic          dump_go = 1'b0;
    logic [LW-1:0] dump_lines = '0;
    logic v1_en, v2_en, pfg_en, fdg_en, busy, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string idle_tag = "R1";

    logic [5:0] vq[$];
    string      tq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ccd_drain_seq #(
        .VW_TICKS(VW), .LEAD_TICKS(LD), .PFG_HOLD_TICKS(PH),
        .FDG_HOLD_TICKS(FH), .LINE_W(LW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_go(flush_go), .dump_go(dump_go),
        .dump_lines(dump_lines), .v1_en(v1_en), .v2_en(v2_en),
        .pfg_en(pfg_en), .fdg_en(fdg_en), .busy(busy), .done(done)
    );

    // vector order: {v1, v2, pfg, fdg, busy, done}
    task automatic push_n(logic [5:0] v, int n, string tag);
        for (int i = 0; i < n; i++) begin
            vq.push_back(v);
            tq.push_back(tag);
        end
    endtask

    task automatic expect_flush(string ctx);
        push_n(6'b010010, LD,      {"R2", ctx});
        push_n(6'b011010, VW-2*LD, {"R2", ctx});
        push_n(6'b010010, LD,      {"R2", ctx});
        push_n(6'b000010, PH,      {"R3", ctx});
        push_n(6'b000001, 1,       {"R7", ctx});
    endtask

    task automatic expect_dump(int n, string ctx);
        for (int l = 0; l < n; l++) begin
            push_n(6'b100010, VW,      {"R4", ctx});
            push_n(6'b010010, LD,      {"R4", ctx});
            push_n(6'b010110, VW-2*LD, {"R4", ctx});
            push_n(6'b010010, LD,      {"R4", ctx});
            push_n(6'b000010, FH,      {"R5", ctx});
        end
        push_n(6'b000001, 1, {"R7", ctx});
    endtask

    // drives one strobe cycle at a falling edge; caller pushes expectations first
    task automatic strobe(logic f, logic d, logic [LW-1:0] n);
        flush_go   = f;
        dump_go    = d;
        dump_lines = n;
        @(negedge clk);
        flush_go   = 1'b0;
        dump_go    = 1'b0;
    endtask

    task automatic wait_drain();
        while (vq.size() != 0) @(negedge clk);
    endtask

    // monitor: one comparison per cycle, a quarter period after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && !finished) begin
                logic [5:0] got, want;
                string tag;
                got = {v1_en, v2_en, pfg_en, fdg_en, busy, done};
                if (vq.size() != 0) begin
                    want = vq.pop_front();
                    tag  = tq.pop_front();
                end else begin
                    want = 6'b000000;
                    tag  = idle_tag;
                end
                total++;
                if (got !== want) begin
                    bad++;
                    $display("FAIL %s: outputs v1,v2,pfg,fdg,busy,done got=%b expected=%b at %0t",
                             tag, got, want, $time);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        total++;
        if ({v1_en, v2_en, pfg_en, fdg_en, busy, done} !== 6'b0) begin
            bad++;
            $display("FAIL R1: reset outputs got=%b expected=000000",
                     {v1_en, v2_en, pfg_en, fdg_en, busy, done});
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2, R3: flush from idle
        expect_flush("");
        strobe(1'b1, 1'b0, '0);
        wait_drain();
        repeat (3) @(negedge clk);

        // R4, R5: single-line discard
        expect_dump(1, "");
        strobe(1'b0, 1'b1, 4'd1);
        wait_drain();
        repeat (2) @(negedge clk);

        // R6: three-line discard, with R8 ignored strobes while busy
        expect_dump(3, "/R6/R8");
        strobe(1'b0, 1'b1, 4'd3);
        repeat (5) @(negedge clk);
        strobe(1'b1, 1'b0, '0);
        repeat (20) @(negedge clk);
        strobe(1'b0, 1'b1, 4'd7);
        wait_drain();
        repeat (2) @(negedge clk);

        // R6: zero-line discard is ignored
        idle_tag = "R6";
        strobe(1'b0, 1'b1, 4'd0);
        repeat (6) @(negedge clk);
        idle_tag = "R1";

        // R9: both strobes together pick the flush
        expect_flush("/R9");
        strobe(1'b1, 1'b1, 4'd2);
        repeat (10) @(negedge clk);
        strobe(1'b0, 1'b1, 4'd2);   // R8: ignored while busy
        wait_drain();

        // R10: strobe in the done cycle (queue just drained) is accepted
        expect_dump(2, "/R10");
        strobe(1'b0, 1'b1, 4'd2);
        wait_drain();
        expect_flush("/R10");
        strobe(1'b1, 1'b0, '0);
        wait_drain();
        repeat (2) @(negedge clk);

        // R6: maximum count
        expect_dump(15, "/R6");
        strobe(1'b0, 1'b1, 4'd15);
        wait_drain();
        repeat (5) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule